// File: doc/BRIEF.md
# Single-bit asynchronous SRAM access controller

This block sits between a simple clocked host and an external asynchronous static RAM of 65,536 one-bit cells. The RAM has sixteen address lines, a separate data input and data output, and two active-low strobes: chip enable and write enable. It has no output enable. The host raises a request with an address, a write flag and one bit of write data. The controller turns this into a correctly timed strobe sequence on the memory pins and answers with a one-cycle acknowledge. On a read, the sampled bit arrives together with that acknowledge.

Every timing window is a whole number of clock cycles set by a parameter. A read holds the chip selected with write enable high for the access window and samples the data output in the last cycle of that window. A write keeps chip enable low for the whole cycle and pulses write enable. The pulse lasts the longer of the pulse-width count and the data-setup count. A hold cycle follows, with write enable high and chip enable still low. A retention input deselects the chip for low-supply operation and blocks new work. When it is released, the controller stays busy for one read-window time before it accepts another access.

Top module: `sram1_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_ce_n and mem_we_n are 1, and host_ack and host_busy are 0.
- R2: A read (host_we=0) drives mem_ce_n=0 and mem_we_n=1 for READ_CYC cycles. It then returns the stored bit on host_rdata with host_ack. host_ack is seen READ_CYC+1 clock edges after the edge that first samples host_req high.
- R3: A write (host_we=1) holds mem_ce_n=0 and drives mem_we_n=0 for exactly max(WP_CYC, DS_CYC) cycles, then one cycle with mem_we_n=1 and mem_ce_n=0. host_ack comes max(WP_CYC, DS_CYC)+2 edges after the request is sampled, and the bit is stored at the rising edge of write enable.
- R4: mem_addr does not change while mem_ce_n stays 0, and mem_d does not change while mem_we_n stays 0.
- R5: mem_we_n is 0 only while mem_ce_n is 0.
- R6: host_ack is high for one cycle only. A host_req that is still high in the acknowledge cycle does not start a new access.
- R7: While ret_req is 1 and no access is in progress, the controller keeps mem_ce_n=1 and host_busy=1 and ignores host_req; no acknowledge is given.
- R8: After ret_req falls, host_busy stays 1 for exactly READ_CYC further clock edges, and mem_ce_n stays 1 until then.
- R9: A ret_req raised during an access does not cut the access short. The access completes with its normal latency and data, and retention begins afterwards.
- R10: The full ADDR_W-bit host address appears unchanged on mem_addr for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| host_req | input | 1 | Access request level, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Cell address |
| host_wdata | input | 1 | Bit to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 1 | Read bit, valid with host_ack |
| host_busy | output | 1 | Access, retention or recovery in progress |
| ret_req | input | 1 | Data-retention request; forces the chip deselected |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_d | output | 1 | Memory data input pin |
| mem_q | input | 1 | Memory data output pin |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The assertions assume that the host keeps host_req high until host_ack and changes it only away from the clock edge. They also assume that ret_req is not dropped while it is being sampled, and that mem_q settles within the read window. The bench drives every input at the falling clock edge and holds each request until its acknowledge. The memory model drives its output with zero delay, so the read window is never shorter than the data path. ret_req is raised both from idle and in the middle of a read, and is released only after the access has been acknowledged.

// File: rtl/sram1_pkg.sv
package sram1_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_WHOLD   = 3'd3,
    ST_RETAIN  = 3'd4,
    ST_RECOVER = 3'd5
  } seq_state_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram1_timer.sv
module sram1_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram1_seq.sv
module sram1_seq
  import sram1_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int READ_CYC = 3,
  parameter int PULSE    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             ret_req,
  input  logic             done,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ce_nx,
  output logic             we_nx,
  output logic             ack,
  output logic             busy
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(PULSE - 1);

  seq_state_e state_q, state_d;
  logic       ack_q, ack_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = RD_LOAD;
    accept   = 1'b0;
    capture  = 1'b0;
    ack_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_req) begin
          state_d = ST_RETAIN;
        end else if (host_req && !ack_q) begin
          accept   = 1'b1;
          load     = 1'b1;
          load_val = host_we ? WR_LOAD : RD_LOAD;
          state_d  = host_we ? ST_WPULSE : ST_READ;
        end
      end
      ST_READ: begin
        if (done) begin
          capture = 1'b1;
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WPULSE: begin
        if (done) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        ack_d   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RETAIN: begin
        if (!ret_req) begin
          load     = 1'b1;
          load_val = RD_LOAD;
          state_d  = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    ce_nx = !((state_d == ST_READ) || (state_d == ST_WPULSE) || (state_d == ST_WHOLD));
    we_nx = (state_d != ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign ack  = ack_q;
  assign busy = (state_q != ST_IDLE);

  // R6
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R6
  no_restart_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !accept);

  // R7
  retain_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && (state_q == ST_IDLE)) |=> (state_q == ST_RETAIN));

endmodule

// File: rtl/sram1_pins.sv
module sram1_pins #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              ce_nx,
  input  logic              we_nx,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wdata,
  input  logic              mem_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_d,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              host_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic              d_q, ce_n_q, we_n_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      d_q    <= 1'b0;
    end else if (accept) begin
      addr_q <= host_addr;
      d_q    <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else if (capture) begin
      rd_q <= mem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
    end else begin
      ce_n_q <= ce_nx;
      we_n_q <= we_nx;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_d      = d_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_we_n   = we_n_q;
  assign host_rdata = rd_q;

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_q && $past(!we_n_q)) |-> $stable(d_q));

  // R5
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);

endmodule

// File: rtl/sram1_ctrl.sv
module sram1_ctrl
  import sram1_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int READ_CYC = 3,
  parameter int WP_CYC   = 2,
  parameter int DS_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wdata,
  output logic              host_ack,
  output logic              host_rdata,
  output logic              host_busy,
  input  logic              ret_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_d,
  input  logic              mem_q,
  output logic              mem_ce_n,
  output logic              mem_we_n
);

  localparam int PULSE = max_i(WP_CYC, DS_CYC);
  localparam int MAXC  = max_i(PULSE, READ_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             load, done, accept, capture, ce_nx, we_nx;
  logic [CNT_W-1:0] load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  sram1_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  sram1_seq #(.CNT_W(CNT_W), .READ_CYC(READ_CYC), .PULSE(PULSE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .host_req (host_req),
    .host_we  (host_we),
    .ret_req  (ret_req),
    .done     (done),
    .load     (load),
    .load_val (load_val),
    .accept   (accept),
    .capture  (capture),
    .ce_nx    (ce_nx),
    .we_nx    (we_nx),
    .ack      (host_ack),
    .busy     (host_busy)
  );

  sram1_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .accept     (accept),
    .capture    (capture),
    .ce_nx      (ce_nx),
    .we_nx      (we_nx),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_q      (mem_q),
    .mem_addr   (mem_addr),
    .mem_d      (mem_d),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .host_rdata (host_rdata)
  );

  // Checker-only counters: write-pulse width and time since retention ended.
  logic [CNT_W-1:0] we_lo_q;
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      we_lo_q <= '0;
      gap_q   <= CNT_W'(READ_CYC);
    end else begin
      if (mem_we_n) we_lo_q <= '0;
      else if (we_lo_q != CNT_W'(MAXC)) we_lo_q <= we_lo_q + 1'b1;
      if (ret_req) gap_q <= '0;
      else if (gap_q != CNT_W'(READ_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  // R3
  write_pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_we_n) |-> (int'(we_lo_q) >= PULSE));

  // R8
  recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(mem_ce_n) |-> (int'(gap_q) >= READ_CYC));

  // R7
  retain_deselect_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ret_req && !host_busy) |=> mem_ce_n);

endmodule

// File: tb/sram1_model.sv
module sram1_model #(
  parameter int AW  = 8,
  parameter int WP  = 2,
  parameter int DS  = 2
) (
  input  logic        clk,
  input  logic [15:0] a,
  input  logic        d,
  output wire         q,
  input  logic        ce_n,
  input  logic        we_n,
  output int          viol,
  output int          last_wp
);

  logic        cells [2**AW];
  int          wp_cnt, ds_cnt;
  logic        d_last, we_last;
  logic [15:0] a_last;

  assign q = (ce_n === 1'b0 && we_n === 1'b1) ? cells[a[AW-1:0]] : 1'bz;

  always @(posedge we_n) begin
    if (ce_n === 1'b0) cells[a[AW-1:0]] <= d;
  end

  initial begin
    viol = 0; last_wp = 0; wp_cnt = 0; ds_cnt = 0;
    d_last = 1'b0; we_last = 1'b1; a_last = '0;
  end

  always @(negedge clk) begin
    if (we_n === 1'b0) begin
      if (ce_n !== 1'b0) viol <= viol + 1;
      if (wp_cnt > 0 && a !== a_last) viol <= viol + 1;
      ds_cnt <= (wp_cnt > 0 && d === d_last) ? ds_cnt + 1 : 1;
      wp_cnt <= wp_cnt + 1;
    end else if (we_last === 1'b0) begin
      last_wp <= wp_cnt;
      if (wp_cnt < WP || ds_cnt < DS) viol <= viol + 1;
      wp_cnt  <= 0;
      ds_cnt  <= 0;
    end
    d_last  <= d;
    a_last  <= a;
    we_last <= we_n;
  end

endmodule

// File: tb/sram1_ctrl_bench.sv
`timescale 1ns/1ps
module sram1_ctrl_bench;

  localparam int RC = 3;
  localparam int WP = 2;
  localparam int DS = 4;
  localparam int PULSE = (WP > DS) ? WP : DS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_wdata = 1'b0, ret_req = 1'b0;
  logic [15:0] host_addr = '0;
  logic        host_ack, host_rdata, host_busy, mem_d, mem_ce_n, mem_we_n;
  logic [15:0] mem_addr;
  wire         mem_q;
  int          viol, last_wp;
  int          checks = 0, failures = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  sram1_ctrl #(.ADDR_W(16), .READ_CYC(RC), .WP_CYC(WP), .DS_CYC(DS)) u_sram1_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .host_busy(host_busy), .ret_req(ret_req),
    .mem_addr(mem_addr), .mem_d(mem_d), .mem_q(mem_q),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n)
  );

  sram1_model #(.AW(8), .WP(WP), .DS(DS)) u_model (
    .clk(clk), .a(mem_addr), .d(mem_d), .q(mem_q), .ce_n(mem_ce_n),
    .we_n(mem_we_n), .viol(viol), .last_wp(last_wp)
  );

  // {write, address, bit}; for reads the bit is the expected value
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 16'h0000, 1'b1}, {1'b1, 16'hFFFF, 1'b1},
    {1'b1, 16'h12A5, 1'b0}, {1'b1, 16'h8A5A, 1'b1},
    {1'b0, 16'h12A5, 1'b0}, {1'b0, 16'h0000, 1'b1},
    {1'b0, 16'h8A5A, 1'b1}, {1'b0, 16'hFFFF, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Called at a falling edge; returns there in the cycle after the ack.
  task automatic do_op(input logic w, input logic [15:0] a, input logic d,
                       output logic rd, output int lat, output logic [15:0] seen);
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    lat = 0; seen = 16'h0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (!mem_ce_n) seen = mem_addr;
      if (host_ack || lat > 40) break;
    end
    rd = host_rdata;
    @(negedge clk);
    chk(mem_ce_n === 1'b1 && host_ack === 1'b0, "R6", int'(mem_ce_n), 1);
    host_req = 1'b0;
  endtask

  task automatic measure_recovery(input string req);
    int n;
    bit ce_ok;
    n = 0; ce_ok = 1;
    ret_req = 1'b0;
    while (1) begin
      @(negedge clk);
      if (mem_ce_n !== 1'b1) ce_ok = 0;
      if (!host_busy || n > 40) break;
      n++;
    end
    chk(n == RC, req, n, RC);
    chk(ce_ok, "R8", int'(ce_ok), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic        rd;
    int          lat;
    logic [15:0] seen;
    bit          ok;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n === 1'b1 && mem_we_n === 1'b1, "R1", int'(mem_ce_n), 1);
    chk(host_ack === 1'b0 && host_busy === 1'b0, "R1", int'(host_busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(mem_ce_n === 1'b1 && mem_we_n === 1'b1 && host_busy === 1'b0, "R1", int'(mem_we_n), 1);

    foreach (VEC[i]) begin
      do_op(VEC[i][17], VEC[i][16:1], VEC[i][0], rd, lat, seen);
      chk(seen == VEC[i][16:1], "R10", int'(seen), int'(VEC[i][16:1]));
      if (VEC[i][17]) begin
        chk(lat == PULSE + 2, "R3", lat, PULSE + 2);
        chk(last_wp == PULSE, "R3", last_wp, PULSE);
      end else begin
        chk(lat == RC + 1, "R2", lat, RC + 1);
        chk(rd === VEC[i][0], "R2", int'(rd), int'(VEC[i][0]));
      end
    end

    // overwrite then read back (R3, R2)
    do_op(1'b1, 16'h12A5, 1'b1, rd, lat, seen);
    do_op(1'b0, 16'h12A5, 1'b0, rd, lat, seen);
    chk(rd === 1'b1, "R2", int'(rd), 1);

    // R7: retention from idle, a pending request is ignored
    ret_req = 1'b1; host_req = 1'b1; host_we = 1'b0; host_addr = 16'h0000;
    ok = 1;
    @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      if (mem_ce_n !== 1'b1 || host_ack !== 1'b0 || host_busy !== 1'b1) ok = 0;
    end
    chk(ok, "R7", int'(ok), 1);
    host_req = 1'b0;
    @(negedge clk);
    measure_recovery("R8");
    do_op(1'b0, 16'h0000, 1'b0, rd, lat, seen);
    chk(lat == RC + 1 && rd === 1'b1, "R8", lat, RC + 1);

    // R9: retention requested in the middle of a read
    host_req = 1'b1; host_we = 1'b0; host_addr = 16'hFFFF;
    lat = 0;
    @(negedge clk);
    lat++;
    ret_req = 1'b1;
    while (!host_ack && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == RC + 1, "R9", lat, RC + 1);
    chk(host_rdata === 1'b1, "R9", int'(host_rdata), 1);
    host_req = 1'b0;
    @(negedge clk);
    chk(host_busy === 1'b1 && mem_ce_n === 1'b1, "R9", int'(host_busy), 1);
    measure_recovery("R9");

    // R4 and R3 as seen by the memory model
    chk(viol == 0, "R4", viol, 0);

    finish_run();
  end

endmodule